// File: doc/BRIEF.md
# Sector Buffered Write Controller

This controller sits between a byte-wide asynchronous-style write bus and a memory array organised in sectors of 128 bytes. A write pulse consists of enable low, write-enable low and output-enable high. A series of such pulses fills an internal sector buffer, in any byte order. There is no explicit commit command. The load phase closes when no further write pulse begins within a fixed number of clock cycles after the previous one ended. The controller then spends a fixed program time erasing the whole sector and rewriting it through the array port. Bytes that were not supplied are written as all ones.

The bus signals arrive already sampled into the clock domain. The controller filters out short strobe glitches. It refuses writes while the power-good input is low and for a settling delay after power-good rises. A busy flag covers the program time, and any write pulse seen while busy is dropped. If a load phase mixes sectors, the first sector is kept and an error flag is raised until the next load phase starts.

Top module: `sector_write_ctrl`

## Requirements
- R1: The address is split into a 10-bit sector number in bits 16..7 and a 7-bit byte offset in bits 6..0. `sector_o` holds the sector of the first byte of the load phase, and every array write during programming lies inside that sector.
- R2: Bytes may be loaded at any offsets, in any order. Each loaded byte is written to the array at its own offset within the sector.
- R3: The address is captured when a write pulse is accepted as asserted, and the data when it is accepted as released. `last_addr_o` and `last_data_o` show those two captures.
- R4: The load phase ends when no new write pulse is accepted within `LOAD_TMO` cycles after the previous release. `busy_o` then rises.
- R5: Programming keeps `busy_o` high for `PROG_CYC` cycles. It issues exactly 128 array writes at offsets 0 to 127 in ascending order.
- R6: An offset that was not loaded during the load phase is written as `FILL` (0xFF).
- R7: No write is accepted while output enable is low, chip enable is high or write enable is high.
- R8: No write is accepted while `pwr_good` is low, nor for `POR_CYC` cycles after it rises.
- R9: A strobe that stays asserted for fewer than `FILT_CYC` consecutive cycles is ignored.
- R10: A write pulse that begins while `busy_o` is high is ignored. The buffer is cleared at the start of every new load phase.
- R11: A byte whose sector differs from the first byte of the phase sets `sector_err_o`, and `sector_o` keeps the first sector. The byte is stored at its offset within the first sector. The flag clears when the next load phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply valid indication |
| we_n_i | input | 1 | Sampled write enable, active low |
| ce_n_i | input | 1 | Sampled chip enable, active low |
| oe_n_i | input | 1 | Sampled output enable, active low |
| addr_i | input | 17 | Byte address |
| data_i | input | 8 | Write data |
| busy_o | output | 1 | Program cycle in progress |
| sector_o | output | 10 | Latched sector number |
| last_addr_o | output | 17 | Address of the last accepted byte |
| last_data_o | output | 8 | Data of the last accepted byte |
| sector_err_o | output | 1 | Sector mismatch within the current phase |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 17 | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
The bench builds the block with `FILT_CYC`=3, `POR_CYC`=20, `LOAD_TMO`=40 and `PROG_CYC`=200. The full real-time windows are replaced by a few dozen cycles. With these values, several complete load-and-program phases fit in a short run. These include the power-up refusal, glitch rejection, timeout-to-busy latency, pulses during busy and sector mismatch. The short filter lets the bench check a two-cycle glitch against a wider accepted pulse. It also lets the bench swap address and data mid-pulse to show the edge on which each one is captured.

// File: rtl/swc_pkg.sv
// Shared types for the sector buffered write controller.
// Assumes a three-phase sequence: idle, loading, programming.
package swc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } swc_state_t;
endpackage

// File: rtl/swc_strobe_filter.sv
// Write strobe qualifier. Combines the bus controls into one write request,
// gates it with power-good and a power-on settle counter, and accepts a change
// only after it has persisted for FILT_CYC samples. Emits a one-cycle pulse on
// each accepted assertion and release. Assumes inputs are already synchronous.
module swc_strobe_filter #(
    parameter int FILT_CYC = 2,
    parameter int POR_CYC  = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic we_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic assert_o,
    output logic release_o
);
    localparam int FC_W  = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam int POR_W = $clog2(POR_CYC + 1) + 1;

    logic [POR_W-1:0] por_cnt;
    logic             por_done;
    logic [FC_W-1:0]  flt_cnt;
    logic             flt_q;
    logic             raw_req;

    assign raw_req = por_done & ~we_n & ~ce_n & oe_n;

    // Power-on settle counter: restarts whenever the supply is not valid.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            por_cnt  <= '0;
            por_done <= 1'b0;
        end else if (por_cnt == POR_W'(POR_CYC)) begin
            por_done <= 1'b1;
        end else begin
            por_cnt <= por_cnt + 1'b1;
        end
    end

    // Persistence filter with edge pulses on each accepted transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_cnt   <= '0;
            flt_q     <= 1'b0;
            assert_o  <= 1'b0;
            release_o <= 1'b0;
        end else begin
            assert_o  <= 1'b0;
            release_o <= 1'b0;
            if (raw_req == flt_q) begin
                flt_cnt <= '0;
            end else if (flt_cnt == FC_W'(FILT_CYC - 1)) begin
                flt_cnt   <= '0;
                flt_q     <= raw_req;
                assert_o  <= raw_req;
                release_o <= ~raw_req;
            end else begin
                flt_cnt <= flt_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swc_sector_buf.sv
// Sector byte buffer with per-byte valid flags. A clear drops all valid flags
// in one cycle; reads of an entry that is not valid return FILL.
// Assumes clear and write never occur in the same cycle.
module swc_sector_buf #(
    parameter int         OFF_W  = 7,
    parameter int         DATA_W = 8,
    parameter logic [7:0] FILL   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BYTES = 1 << OFF_W;

    logic [DATA_W-1:0] mem [BYTES];
    logic [BYTES-1:0]  vld;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        // Storage and valid flag of one buffer entry.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                vld[i] <= 1'b0;
            end else if (wr && wr_off == OFF_W'(i)) begin
                vld[i] <= 1'b1;
                mem[i] <= wr_data;
            end
        end
    end

    // Read mux substituting the fill value for bytes never loaded.
    always_comb begin
        rd_data = vld[rd_off] ? mem[rd_off] : DATA_W'(FILL);
    end
endmodule

// File: rtl/swc_seq.sv
// Load/program sequencer. Opens a load phase on the first accepted strobe,
// latches the sector, routes bytes into the buffer, closes the phase after
// LOAD_TMO idle cycles and then runs a PROG_CYC program window whose first
// 2**OFF_W cycles write the sector to the array. Assumes PROG_CYC > 2**OFF_W.
module swc_seq
    import swc_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int OFF_W    = 7,
    parameter int DATA_W   = 8,
    parameter int LOAD_TMO = 15000,
    parameter int PROG_CYC = 1000000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    assert_i,
    input  logic                    release_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic                    busy_o,
    output logic [ADDR_W-OFF_W-1:0] sector_o,
    output logic [ADDR_W-1:0]       last_addr_o,
    output logic [DATA_W-1:0]       last_data_o,
    output logic                    err_o,
    output logic                    buf_clr_o,
    output logic                    buf_wr_o,
    output logic [OFF_W-1:0]        buf_off_o,
    output logic                    arr_we_o,
    output logic [OFF_W-1:0]        prog_off_o
);
    localparam int SECT_W = ADDR_W - OFF_W;
    localparam int BYTES  = 1 << OFF_W;
    localparam int TMR_W  = $clog2(LOAD_TMO + 1);
    localparam int PC_W   = $clog2(PROG_CYC + 1);

    swc_state_t         state;
    logic               pend;
    logic [OFF_W-1:0]   off_q;
    logic [TMR_W-1:0]   tmr;
    logic [PC_W-1:0]    pcnt;
    logic [SECT_W-1:0]  in_sect;

    assign in_sect    = addr_i[ADDR_W-1:OFF_W];
    assign busy_o     = (state == ST_PROG);
    assign buf_clr_o  = assert_i && (state == ST_IDLE);
    assign buf_wr_o   = release_i && pend && (state == ST_LOAD);
    assign buf_off_o  = off_q;
    assign arr_we_o   = (state == ST_PROG) && (pcnt < PC_W'(BYTES));
    assign prog_off_o = pcnt[OFF_W-1:0];

    // Phase state machine with load timeout and program window counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            pend        <= 1'b0;
            off_q       <= '0;
            tmr         <= '0;
            pcnt        <= '0;
            sector_o    <= '0;
            last_addr_o <= '0;
            last_data_o <= '0;
            err_o       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (assert_i) begin
                        sector_o    <= in_sect;
                        off_q       <= addr_i[OFF_W-1:0];
                        last_addr_o <= addr_i;
                        err_o       <= 1'b0;
                        pend        <= 1'b1;
                        tmr         <= '0;
                        state       <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (assert_i) begin
                        off_q       <= addr_i[OFF_W-1:0];
                        last_addr_o <= addr_i;
                        pend        <= 1'b1;
                        tmr         <= '0;
                        if (in_sect != sector_o) begin
                            err_o <= 1'b1;
                        end
                    end else if (release_i && pend) begin
                        last_data_o <= data_i;
                        pend        <= 1'b0;
                        tmr         <= '0;
                    end else if (!pend) begin
                        if (tmr == TMR_W'(LOAD_TMO - 1)) begin
                            state <= ST_PROG;
                            pcnt  <= '0;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (pcnt == PC_W'(PROG_CYC - 1)) begin
                        pcnt  <= '0;
                        state <= ST_IDLE;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sector_write_ctrl.sv
// Top of the sector buffered write controller: strobe qualifier, sequencer
// and sector buffer. The array port is driven straight from the sequencer's
// program counter and the buffer read mux.
module sector_write_ctrl #(
    parameter int         ADDR_W   = 17,
    parameter int         OFF_W    = 7,
    parameter int         DATA_W   = 8,
    parameter int         FILT_CYC = 2,
    parameter int         POR_CYC  = 500000,
    parameter int         LOAD_TMO = 15000,
    parameter int         PROG_CYC = 1000000,
    parameter logic [7:0] FILL     = 8'hFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_good,
    input  logic                    we_n_i,
    input  logic                    ce_n_i,
    input  logic                    oe_n_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic                    busy_o,
    output logic [ADDR_W-OFF_W-1:0] sector_o,
    output logic [ADDR_W-1:0]       last_addr_o,
    output logic [DATA_W-1:0]       last_data_o,
    output logic                    sector_err_o,
    output logic                    arr_we_o,
    output logic [ADDR_W-1:0]       arr_addr_o,
    output logic [DATA_W-1:0]       arr_data_o
);
    logic             str_assert;
    logic             str_release;
    logic             buf_clr;
    logic             buf_wr;
    logic [OFF_W-1:0] buf_off;
    logic [OFF_W-1:0] prog_off;

    swc_strobe_filter #(
        .FILT_CYC (FILT_CYC),
        .POR_CYC  (POR_CYC)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .we_n      (we_n_i),
        .ce_n      (ce_n_i),
        .oe_n      (oe_n_i),
        .assert_o  (str_assert),
        .release_o (str_release)
    );

    swc_seq #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .DATA_W   (DATA_W),
        .LOAD_TMO (LOAD_TMO),
        .PROG_CYC (PROG_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .assert_i    (str_assert),
        .release_i   (str_release),
        .addr_i      (addr_i),
        .data_i      (data_i),
        .busy_o      (busy_o),
        .sector_o    (sector_o),
        .last_addr_o (last_addr_o),
        .last_data_o (last_data_o),
        .err_o       (sector_err_o),
        .buf_clr_o   (buf_clr),
        .buf_wr_o    (buf_wr),
        .buf_off_o   (buf_off),
        .arr_we_o    (arr_we_o),
        .prog_off_o  (prog_off)
    );

    swc_sector_buf #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W),
        .FILL   (FILL)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr      (buf_wr),
        .wr_off  (buf_off),
        .wr_data (data_i),
        .rd_off  (prog_off),
        .rd_data (arr_data_o)
    );

    assign arr_addr_o = {sector_o, prog_off};
endmodule

// File: rtl/swc_checker.sv
// Protocol checker for sector_write_ctrl, attached by bind below.
module swc_checker #(
    parameter int ADDR_W = 17,
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pwr_good,
    input logic                    busy_o,
    input logic [ADDR_W-OFF_W-1:0] sector_o,
    input logic [ADDR_W-1:0]       last_addr_o,
    input logic                    arr_we_o,
    input logic [ADDR_W-1:0]       arr_addr_o
);
    // R5: array writes only inside the program window
    a_r5_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);

    // R1: every array write targets the latched sector
    a_r1_write_in_sector: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> (arr_addr_o[ADDR_W-1:OFF_W] == sector_o));

    // R1: sector stays fixed through programming
    a_r1_sector_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(sector_o));

    // R5: consecutive array writes step up by one offset
    a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we_o && $past(arr_we_o)) |->
        (arr_addr_o[OFF_W-1:0] == OFF_W'($past(arr_addr_o[OFF_W-1:0]) + 1'b1)));

    // R10: nothing is captured while busy
    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(last_addr_o));

    // R8: no capture once power has been seen invalid
    a_r8_no_power_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pwr_good) |=> $stable(last_addr_o));
endmodule

bind sector_write_ctrl swc_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .busy_o      (busy_o),
    .sector_o    (sector_o),
    .last_addr_o (last_addr_o),
    .arr_we_o    (arr_we_o),
    .arr_addr_o  (arr_addr_o)
);

// File: tb/sector_write_ctrl_bench.sv
module sector_write_ctrl_bench;
    localparam int FILT = 3;
    localparam int POR  = 20;
    localparam int TMO  = 40;
    localparam int PROG = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b0;
    logic        we_n_i = 1'b1;
    logic        ce_n_i = 1'b0;
    logic        oe_n_i = 1'b1;
    logic [16:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic        busy_o;
    logic [9:0]  sector_o;
    logic [16:0] last_addr_o;
    logic [7:0]  last_data_o;
    logic        sector_err_o;
    logic        arr_we_o;
    logic [16:0] arr_addr_o;
    logic [7:0]  arr_data_o;

    sector_write_ctrl #(
        .FILT_CYC (FILT), .POR_CYC (POR), .LOAD_TMO (TMO), .PROG_CYC (PROG)
    ) u_sector_write_ctrl (
        .clk (clk), .rst_n (rst_n), .pwr_good (pwr_good),
        .we_n_i (we_n_i), .ce_n_i (ce_n_i), .oe_n_i (oe_n_i),
        .addr_i (addr_i), .data_i (data_i),
        .busy_o (busy_o), .sector_o (sector_o),
        .last_addr_o (last_addr_o), .last_data_o (last_data_o),
        .sector_err_o (sector_err_o), .arr_we_o (arr_we_o),
        .arr_addr_o (arr_addr_o), .arr_data_o (arr_data_o)
    );

    always #5 clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    typedef struct { logic [16:0] a; logic [7:0] d; } item_t;
    item_t sbq[$];

    logic [7:0] mbuf [128];
    bit         mval [128];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected array writes and compare
    always @(negedge clk) begin
        if (rst_n && arr_we_o && !done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R5 unexpected array write", int'(arr_addr_o), 0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(arr_addr_o == it.a, "R1 array address", int'(arr_addr_o), int'(it.a));
                check(arr_data_o == it.d, (it.d == 8'hFF) ? "R6 array data" : "R2 array data",
                      int'(arr_data_o), int'(it.d));
            end
        end
    end

    task automatic strobe(input logic [16:0] a, input logic [7:0] d,
                          input logic ce, input logic oe, input int width);
        @(negedge clk);
        addr_i = a; data_i = ~d; ce_n_i = ce; oe_n_i = oe; we_n_i = 1'b0;
        repeat (FILT + 1) @(negedge clk);
        addr_i = ~a; data_i = d;
        repeat (width - FILT - 1) @(negedge clk);
        we_n_i = 1'b1;
        repeat (FILT + 1) @(negedge clk);
        data_i = ~d; ce_n_i = 1'b0; oe_n_i = 1'b1;
    endtask

    task automatic start_phase();
        for (int i = 0; i < 128; i++) mval[i] = 1'b0;
    endtask

    task automatic load(input logic [16:0] a, input logic [7:0] d);
        strobe(a, d, 1'b0, 1'b1, 8);
        check(last_addr_o == a, "R3 address capture", int'(last_addr_o), int'(a));
        check(last_data_o == d, "R3 data capture", int'(last_data_o), int'(d));
        mbuf[a[6:0]] = d;
        mval[a[6:0]] = 1'b1;
    endtask

    task automatic expect_sector(input logic [9:0] s);
        for (int i = 0; i < 128; i++) begin
            item_t it;
            it.a = {s, 7'(i)};
            it.d = mval[i] ? mbuf[i] : 8'hFF;
            sbq.push_back(it);
        end
    endtask

    // Wait for the timeout and the program window, checking both lengths
    task automatic run_program(input logic [9:0] s);
        int k;
        k = 0;
        expect_sector(s);
        while (!busy_o && k < TMO + 20) begin @(negedge clk); k++; end
        check(k >= TMO - 1 && k <= TMO + 1, "R4 timeout to busy", k, TMO);
        check(sector_o == s, "R1 latched sector", int'(sector_o), int'(s));
        k = 0;
        while (busy_o && k < PROG + 20) begin @(negedge clk); k++; end
        check(k >= PROG - 1 && k <= PROG + 1, "R5 busy length", k, PROG);
        check(sbq.size() == 0, "R5 write count", sbq.size(), 0);
    endtask

    task automatic quiet(input string req);
        logic [16:0] la;
        bit          saw;
        la  = last_addr_o;
        saw = 1'b0;
        repeat (TMO + 20) begin @(negedge clk); if (busy_o) saw = 1'b1; end
        check(!saw, req, int'(saw), 0);
        check(last_addr_o == la, req, int'(last_addr_o), int'(la));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(busy_o == 1'b0, "R5 reset busy", int'(busy_o), 0);
        check(arr_we_o == 1'b0, "R5 reset array write", int'(arr_we_o), 0);
        check(sector_err_o == 1'b0, "R11 reset error", int'(sector_err_o), 0);
        check(last_addr_o == 17'd0, "R3 reset address", int'(last_addr_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: no power, then pulse right after power-good before settling
        strobe(17'h00321, 8'h11, 1'b0, 1'b1, 8);
        quiet("R8 write without power");
        pwr_good = 1'b1;
        strobe(17'h00321, 8'h11, 1'b0, 1'b1, 8);
        quiet("R8 write during settle");
        repeat (POR + 5) @(negedge clk);

        // R7: inhibit conditions
        strobe(17'h00444, 8'h22, 1'b0, 1'b0, 8);
        quiet("R7 output enable low");
        strobe(17'h00444, 8'h22, 1'b1, 1'b1, 8);
        quiet("R7 chip enable high");

        // R9: short glitch
        @(negedge clk);
        addr_i = 17'h00555; we_n_i = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        we_n_i = 1'b1;
        quiet("R9 glitch ignored");

        // R2: out-of-order loads into sector 5, R6 for the rest
        start_phase();
        load({10'd5, 7'd7},   8'hA7);
        load({10'd5, 7'd3},   8'h33);
        load({10'd5, 7'd127}, 8'h7F);
        load({10'd5, 7'd0},   8'h00);
        run_program(10'd5);

        // R10: pulse while busy is dropped
        start_phase();
        load({10'd9, 7'd20}, 8'h5C);
        expect_sector(10'd9);
        wait (busy_o);
        @(negedge clk);
        strobe({10'd12, 7'd1}, 8'h99, 1'b0, 1'b1, 8);
        check(busy_o == 1'b1, "R10 still busy after pulse", int'(busy_o), 1);
        wait (!busy_o);
        @(negedge clk);
        check(sbq.size() == 0, "R5 write count", sbq.size(), 0);
        quiet("R10 pulse during busy ignored");

        // R11: sector mismatch keeps first sector
        start_phase();
        load({10'd2, 7'd1}, 8'hC1);
        check(sector_err_o == 1'b0, "R11 no error yet", int'(sector_err_o), 0);
        load({10'd3, 7'd4}, 8'hC4);
        check(sector_err_o == 1'b1, "R11 error set", int'(sector_err_o), 1);
        check(sector_o == 10'd2, "R11 first sector kept", int'(sector_o), 2);
        run_program(10'd2);

        // R10/R11: next phase clears error and buffer
        start_phase();
        load({10'd2, 7'd10}, 8'hDA);
        check(sector_err_o == 1'b0, "R11 error cleared", int'(sector_err_o), 0);
        run_program(10'd2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule